// File: doc/BRIEF.md
# Encoded-Select Arithmetic, Logic and Shift Unit

This block is the combinational execution unit of a simple register-to-register datapath. It takes two operands of parameterized width and a 5-bit operation code. It returns one result together with four status bits: overflow, carry, negative and zero. A control unit uses the status bits to decide conditional branches.

One adder serves every arithmetic operation: increment, addition, subtraction, decrement and pass-through. The upper two code bits select the arithmetic group. The lower three bits choose the second adder input and the carry-in. The bitwise operations, a transfer of the second operand and single-position shifts of the second operand are also selected through the same code. Any code outside the defined set gives a zero result. The unit holds no state, so its outputs follow its inputs within the same cycle.

Top module: `fsel_alu`

## Requirements
- R1: Codes 00000 and 00111 give f = a, and code 00001 gives f = a + 1, all modulo 2^W.
- R2: Code 00010 gives f = a + b, and code 00011 gives f = a + b + 1, modulo 2^W.
- R3: Code 00100 gives f = a + ~b, code 00101 gives f = a - b, and code 00110 gives f = a - 1, modulo 2^W.
- R4: Code 01000 gives a AND b, code 01010 gives a OR b, code 01100 gives a XOR b, and code 01110 gives NOT a.
- R5: Code 10000 gives f = b.
- R6: Code 10100 shifts b right by one position with 0 entering the top bit. Code 11000 shifts b left by one position with 0 entering bit 0.
- R7: For codes with fs[4:3] = 00, cout is the unsigned carry out of a + y + cin, where (y, cin) is (0,0), (0,1), (b,0), (b,1), (~b,0), (~b,1), (all-ones,0) or (all-ones,1) for fs[2:0] = 0 to 7. For every other code, cout is 0.
- R8: For codes with fs[4:3] = 00, ovf is 1 exactly when the signed two's-complement sum a + y + cin falls outside the W-bit signed range. For every other code, ovf is 0.
- R9: neg equals bit W-1 of f, and zero is 1 exactly when every bit of f is 0.
- R10: Any code outside the set listed in R1 to R6 gives f = 0, cout = 0, ovf = 0, zero = 1 and neg = 0.
- R11: The unit is purely combinational. A change on a_in, b_in or fs appears at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand |
| b_in | input | W | Second operand; also the source for transfer and shifts |
| fs | input | 5 | Operation code |
| f | output | W | Result |
| ovf | output | 1 | Signed overflow of an arithmetic code |
| cout | output | 1 | Carry out of an arithmetic code |
| neg | output | 1 | Result sign bit |
| zero | output | 1 | Result is all zeros |

## Verification
The unit holds no state, so any fault in the second-operand selection, the carry-in, the group decode or the shift wiring appears on f and the flags as soon as the inputs settle, in the same cycle as the stimulus. A bad adder-input choice shows up as a wrong result or a wrong carry on the specific code that uses it. For this reason, every defined code is driven with operands chosen to reach carry and signed-overflow limits. A decode that leaks into an undefined code shows up as a nonzero result, or as a flag raised where the zero default should hold. The bench checks all undefined codes for this.

// File: rtl/fsel_alu.sv
module fsel_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [4:0]   fs,
  output logic [W-1:0] f,
  output logic         ovf,
  output logic         cout,
  output logic         neg,
  output logic         zero
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_sel;
  logic [W:0]   sum_w;
  logic         is_arith;
  logic [W-1:0] logic_res;
  logic [W-1:0] move_res;

  assign is_arith = (fs[4:3] == 2'b00);

  always_comb begin
    unique case (fs[2:1])
      2'b00:   y_sel = '0;
      2'b01:   y_sel = b_in;
      2'b10:   y_sel = ~b_in;
      default: y_sel = '1;
    endcase
  end

  assign sum_w = {1'b0, a_in} + {1'b0, y_sel} + {{W{1'b0}}, fs[0]};

  always_comb begin
    logic_res = '0;
    if (!fs[0]) begin
      unique case (fs[2:1])
        2'b00:   logic_res = a_in & b_in;
        2'b01:   logic_res = a_in | b_in;
        2'b10:   logic_res = a_in ^ b_in;
        default: logic_res = ~a_in;
      endcase
    end
  end

  always_comb begin
    unique case (fs)
      5'b10000: move_res = b_in;
      5'b10100: move_res = {1'b0, b_in[MSB:1]};
      5'b11000: move_res = {b_in[MSB-1:0], 1'b0};
      default:  move_res = '0;
    endcase
  end

  always_comb begin
    unique case (fs[4:3])
      2'b00:   f = sum_w[MSB:0];
      2'b01:   f = logic_res;
      default: f = move_res;
    endcase
  end

  assign cout = is_arith & sum_w[W];
  assign ovf  = is_arith & (a_in[MSB] == y_sel[MSB]) & (sum_w[MSB] != a_in[MSB]);
  assign neg  = f[MSB];
  assign zero = ~|f;
endmodule

module fsel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [4:0]   fs,
  input logic [W-1:0] f,
  input logic         ovf,
  input logic         cout,
  input logic         neg,
  input logic         zero
);
  always_comb begin
    a_r7_no_carry_outside: assert (fs[4:3] == 2'b00 || !cout);
    a_r8_no_ovf_outside: assert (fs[4:3] == 2'b00 || !ovf);
    a_r1_pass_a: assert (fs != 5'b00000 || (f == a_in && !cout && !ovf));
    a_r5_pass_b: assert (fs != 5'b10000 || f == b_in);
    a_r6_shl_fill: assert (fs != 5'b11000 || (f[0] == 1'b0 && f[W-1:1] == b_in[W-2:0]));
    a_r6_shr_fill: assert (fs != 5'b10100 || (f[W-1] == 1'b0 && f[W-2:0] == b_in[W-1:1]));
    a_r9_zero_not_neg: assert (!zero || !neg);
    a_r10_unused_logic: assert (!(fs[4:3] == 2'b01 && fs[0]) || (f == '0 && zero));
  end
endmodule

bind fsel_alu fsel_alu_chk #(.W(W)) i_fsel_alu_chk (.*);

// File: tb/test_fsel_alu.sv
module test_fsel_alu;
  localparam int W = 8;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic [W-1:0] a_in, b_in, f;
  logic [4:0] fs;
  logic ovf, cout, neg, zero;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsel_alu #(.W(W)) i_fsel_alu (.a_in(a_in), .b_in(b_in), .fs(fs), .f(f),
    .ovf(ovf), .cout(cout), .neg(neg), .zero(zero));

  function automatic bit defined(input logic [4:0] c);
    return (c[4:3] == 2'b00) || (c[4:3] == 2'b01 && !c[0]) ||
           c == 5'b10000 || c == 5'b10100 || c == 5'b11000;
  endfunction

  task automatic expect_out(input logic [4:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                            output logic [W-1:0] ef, output logic ec, output logic ev);
    longint ua, uy, sa, sy, tot, stot;
    int ci;
    ef = '0; ec = 0; ev = 0;
    ua = longint'(a); sa = longint'($signed(a));
    if (c[4:3] == 2'b00) begin
      ci = c[0];
      case (c[2:1])
        2'b00: begin uy = 0; sy = 0; end
        2'b01: begin uy = longint'(b); sy = longint'($signed(b)); end
        2'b10: begin uy = (longint'(1) << W) - 1 - longint'(b); sy = -longint'($signed(b)) - 1; end
        default: begin uy = (longint'(1) << W) - 1; sy = -1; end
      endcase
      tot = ua + uy + ci;
      stot = sa + sy + ci;
      ef = tot[W-1:0];
      ec = (tot >= (longint'(1) << W));
      ev = (stot > (longint'(1) << (W-1)) - 1) || (stot < -(longint'(1) << (W-1)));
    end else if (c == 5'b01000) ef = a & b;
    else if (c == 5'b01010) ef = a | b;
    else if (c == 5'b01100) ef = a ^ b;
    else if (c == 5'b01110) ef = ~a;
    else if (c == 5'b10000) ef = b;
    else if (c == 5'b10100) ef = b / 2;
    else if (c == 5'b11000) ef = W'(b * 2);
  endtask

  task automatic apply_check(input logic [4:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                             input string req);
    logic [W-1:0] ef;
    logic ec, ev;
    expect_out(c, a, b, ef, ec, ev);
    @(negedge clk);
    fs = c; a_in = a; b_in = b;
    #1;
    n_chk++;
    if (f !== ef || cout !== ec || ovf !== ev || neg !== ef[W-1] || zero !== (ef == '0)) begin
      n_fail++;
      $display("FAIL %s fs=%b a=%h b=%h: got f=%h c=%b v=%b n=%b z=%b, expected f=%h c=%b v=%b n=%b z=%b",
               req, c, a, b, f, cout, ovf, neg, zero, ef, ec, ev, ef[W-1], (ef == '0));
    end
  endtask

  task automatic t_idle;
    apply_check(5'b00000, '0, '0, "R9 idle zero");
  endtask

  task automatic t_pass_inc;
    apply_check(5'b00000, 8'h5A, 8'h33, "R1");
    apply_check(5'b00111, 8'h80, 8'h01, "R1 R7");
    apply_check(5'b00001, 8'h7F, 8'h00, "R1 R8");
    apply_check(5'b00001, 8'hFF, 8'h00, "R1 R7");
  endtask

  task automatic t_add;
    apply_check(5'b00010, 8'h12, 8'h34, "R2");
    apply_check(5'b00010, 8'h80, 8'h80, "R2 R7 R8");
    apply_check(5'b00011, 8'h7F, 8'h00, "R2 R8");
    apply_check(5'b00011, 8'hFF, 8'hFF, "R2 R7");
  endtask

  task automatic t_sub;
    apply_check(5'b00100, 8'h10, 8'h03, "R3");
    apply_check(5'b00101, 8'h80, 8'h01, "R3 R8");
    apply_check(5'b00101, 8'h05, 8'h05, "R3 R7 R9");
    apply_check(5'b00101, 8'h03, 8'h05, "R3 R9");
    apply_check(5'b00110, 8'h00, 8'h00, "R3 R7");
    apply_check(5'b00110, 8'h80, 8'h00, "R3 R8");
  endtask

  task automatic t_logic;
    apply_check(5'b01000, 8'hF0, 8'h3C, "R4 R7 R8");
    apply_check(5'b01010, 8'hF0, 8'h0C, "R4");
    apply_check(5'b01100, 8'hAA, 8'hAA, "R4 R9");
    apply_check(5'b01110, 8'h0F, 8'hFF, "R4 R9");
  endtask

  task automatic t_move;
    apply_check(5'b10000, 8'h11, 8'h9C, "R5");
    apply_check(5'b10100, 8'h00, 8'h81, "R6");
    apply_check(5'b11000, 8'hFF, 8'h81, "R6 R7");
    apply_check(5'b11000, 8'h00, 8'h80, "R6 R9");
  endtask

  task automatic t_unused;
    for (int k = 0; k < 32; k++) begin
      if (!defined(5'(k))) apply_check(5'(k), 8'hFF, 8'hFF, "R10");
    end
  endtask

  task automatic t_comb;
    @(negedge clk);
    fs = 5'b00010; a_in = 8'h01; b_in = 8'h02;
    #0.5;
    fs = 5'b01100; a_in = 8'hC3;
    #0.5;
    n_chk++;
    if (f !== 8'hC1) begin
      n_fail++;
      $display("FAIL R11 no-clock update: got f=%h, expected f=%h", f, 8'hC1);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got cycle %0d, expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    fs = '0; a_in = '0; b_in = '0;
    t_idle();
    t_pass_inc();
    t_add();
    t_sub();
    t_logic();
    t_move();
    t_unused();
    t_comb();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule